// File: doc/BRIEF.md
# Banked Program Memory Address Mapper

This block sits between an 8051-style CPU core and its 128 kB of on-chip program flash. It turns each 16-bit CPU address into a physical flash address. The lower half of the CPU space always reaches bank 0. The upper half is a 32 kB window onto one of banks 1 to 3. Instruction fetches and data-style flash accesses pass through that same window, but each chooses its bank from its own field of a bank-select register. A fetch can therefore run code from one bank while the program reads or writes constants in another.

The block also guards the flash. Data writes get a strobe only while a program-store write-enable bit is set. The top 1 kB of bank 3 is reserved: any access that lands there is refused and raises a sticky fault flag. A 256-byte scratchpad above the banked space is open to data accesses only. Every write is reported with its 1 kB sector index. A build-time option replaces the banking with a flat 64 kB map.

All results are registered, so each output appears one clock after the request that caused it. The mapping for a request uses the register contents in force at the moment the request is made.

Top module: `pmem_bank_map`

## Requirements
- R1: After reset the fetch and data bank fields both select bank 1, write enable is clear, the fault flag is low and no strobe is active.
- R2: A CPU address below 0x8000 maps to the same physical address (bank 0) for fetch and data access, whatever the bank fields hold.
- R3: A fetch at CPU address A >= 0x8000 maps to physical B*0x8000 + (A - 0x8000). B is the fetch field, bits [1:0] of a bank-register write (cfg_sel=0). A field value of 0 counts as bank 1.
- R4: A non-scratchpad data access at A >= 0x8000 uses the data field, bits [5:4] of the same bank-register write, with the same rule and the same 0-means-1 rule, independently of the fetch field. A read raises data_rd; a write never raises data_rd.
- R5: An access whose physical address lies in 0x1FC00 to 0x1FFFF gives no strobe (fetch_stb, data_rd, data_wr all low) and sets fault. Fault stays high until reset.
- R6: A data write (dat_we=1) raises data_wr only while write enable is set. Write enable is bit 0 of a write with cfg_sel=1. Otherwise the write is ignored.
- R7: A data access with dat_scratch=1 maps to 0x20000 + dat_addr[7:0]. A fetch never yields a physical address of 0x20000 or above.
- R8: data_sector carries the physical address divided by 1024 for the data access of the previous cycle, including every write.
- R9: Each output appears one clock after its request. A register write in the same cycle as a request changes the mapping only from the next request onward.
- R10: With FLAT=1 the bank fields have no effect, 0x0000 to 0xFFFF map directly to physical addresses, and nothing in that range faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_addr | input | 16 | CPU fetch address |
| dat_req | input | 1 | Data-style flash access request |
| dat_we | input | 1 | 1 = write, 0 = read |
| dat_scratch | input | 1 | Access targets the scratchpad |
| dat_addr | input | 16 | CPU data address |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = bank register, 1 = program-store control |
| cfg_wdata | input | 8 | Register write data |
| fetch_phys | output | 18 | Physical fetch address |
| fetch_stb | output | 1 | Fetch strobe |
| data_phys | output | 18 | Physical data address |
| data_rd | output | 1 | Data read strobe |
| data_wr | output | 1 | Data write strobe |
| data_sector | output | 8 | 1 kB sector index of data_phys |
| fault | output | 1 | Sticky reserved-region fault |

## Verification
The assertions assume that the inputs are stable around the rising edge and that a data request's address and direction belong to the same cycle as dat_req. They place no limit on how fetch, data and register traffic overlap. The stimulus changes inputs only on the falling edge. It drives the directed corner cases first, then mixes random fetches, reads, writes, scratchpad hits and register writes in any combination in the same cycle. Both the banked and the flat build receive this stimulus, so overlapping traffic is covered while every input stays legal.

// File: rtl/pmem_bank_map.sv
module pmem_bank_map #(
  parameter int AW       = 16,
  parameter int BW       = 2,
  parameter int SECT_LOG = 10,
  parameter int SCR_LOG  = 8,
  parameter int RW       = 8,
  parameter bit FLAT     = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetch_req,
  input  logic [AW-1:0]          fetch_addr,
  input  logic                   dat_req,
  input  logic                   dat_we,
  input  logic                   dat_scratch,
  input  logic [AW-1:0]          dat_addr,
  input  logic                   cfg_we,
  input  logic                   cfg_sel,
  input  logic [RW-1:0]          cfg_wdata,
  output logic [AW+1:0]          fetch_phys,
  output logic                   fetch_stb,
  output logic [AW+1:0]          data_phys,
  output logic                   data_rd,
  output logic                   data_wr,
  output logic [AW+1-SECT_LOG:0] data_sector,
  output logic                   fault
);
  localparam int PW = AW + 2;
  localparam int SW = PW - SECT_LOG;
  localparam logic [PW-1:0] SCR_BASE = PW'(1) << (AW + 1);
  localparam logic [SW-1:0] RSV_SEC  = SW'((SCR_BASE >> SECT_LOG) - 1);

  logic [BW-1:0] fbank_q, dbank_q;
  logic          wen_q;

  function automatic logic [PW-1:0] map_addr(input logic [AW-1:0] a, input logic [BW-1:0] b);
    logic [BW-1:0] eff;
    eff = (b == '0) ? BW'(1) : b;
    if (FLAT || !a[AW-1]) return PW'(a);
    return PW'({eff, a[AW-2:0]});
  endfunction

  logic [PW-1:0] f_phys, d_phys;
  logic          f_rsv, d_rsv;

  assign f_phys = map_addr(fetch_addr, fbank_q);
  assign d_phys = dat_scratch ? (SCR_BASE | PW'(dat_addr[SCR_LOG-1:0])) : map_addr(dat_addr, dbank_q);
  assign f_rsv  = !FLAT && (f_phys[PW-1:SECT_LOG] == RSV_SEC);
  assign d_rsv  = !FLAT && (d_phys[PW-1:SECT_LOG] == RSV_SEC);

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[RW-1:6], cfg_wdata[3:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fbank_q <= BW'(1);
      dbank_q <= BW'(1);
      wen_q   <= 1'b0;
    end else if (cfg_we) begin
      if (!cfg_sel) begin
        fbank_q <= cfg_wdata[BW-1:0];
        dbank_q <= cfg_wdata[4 +: BW];
      end else begin
        wen_q <= cfg_wdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_phys  <= '0;
      fetch_stb   <= 1'b0;
      data_phys   <= '0;
      data_rd     <= 1'b0;
      data_wr     <= 1'b0;
      data_sector <= '0;
      fault       <= 1'b0;
    end else begin
      fetch_phys  <= f_phys;
      fetch_stb   <= fetch_req && !f_rsv;
      data_phys   <= d_phys;
      data_rd     <= dat_req && !dat_we && !d_rsv;
      data_wr     <= dat_req && dat_we && wen_q && !d_rsv;
      data_sector <= d_phys[PW-1:SECT_LOG];
      if ((fetch_req && f_rsv) || (dat_req && d_rsv)) fault <= 1'b1;
    end
  end

  // R2
  low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_addr[AW-1]) |=> (fetch_phys == PW'($past(fetch_addr))));
  // R5
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  // R5
  no_rsv_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd || data_wr) |-> (FLAT || data_sector != RSV_SEC));
  // R6
  wr_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |-> $past(wen_q));
  // R4
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_rd && data_wr));
  // R7
  fetch_no_scratch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |-> !fetch_phys[PW-1]);
endmodule

// File: tb/pmem_bank_map_bench.sv
module pmem_bank_map_bench;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic fetch_req = 0, dat_req = 0, dat_we = 0, dat_scratch = 0, cfg_we = 0, cfg_sel = 0;
  logic [15:0] fetch_addr = 0, dat_addr = 0;
  logic [7:0] cfg_wdata = 0;

  logic [17:0] fp_b, dp_b, fp_f, dp_f;
  logic fs_b, rd_b, wr_b, ft_b, fs_f, rd_f, wr_f, ft_f;
  logic [7:0] sc_b, sc_f;

  pmem_bank_map u_pmem_bank_map (.clk, .rst_n, .fetch_req, .fetch_addr, .dat_req, .dat_we,
    .dat_scratch, .dat_addr, .cfg_we, .cfg_sel, .cfg_wdata, .fetch_phys(fp_b), .fetch_stb(fs_b),
    .data_phys(dp_b), .data_rd(rd_b), .data_wr(wr_b), .data_sector(sc_b), .fault(ft_b));
  pmem_bank_map #(.FLAT(1'b1)) u_pmem_bank_map_flat (.clk, .rst_n, .fetch_req, .fetch_addr, .dat_req,
    .dat_we, .dat_scratch, .dat_addr, .cfg_we, .cfg_sel, .cfg_wdata, .fetch_phys(fp_f), .fetch_stb(fs_f),
    .data_phys(dp_f), .data_rd(rd_f), .data_wr(wr_f), .data_sector(sc_f), .fault(ft_f));

  int total = 0, bad = 0;
  string tag = "R1";

  int mf, md, mw;
  int e_fp[2], e_dp[2], e_sc[2];
  bit e_fs[2], e_rd[2], e_wr[2], e_ft[2];

  function automatic int phys_of(int a, int b, bit flat);
    if (flat || a < 32768) return a;
    return ((b == 0) ? 1 : b) * 32768 + (a - 32768);
  endfunction

  function automatic bit in_rsv(int p, bit flat);
    return !flat && p >= 'h1FC00 && p < 'h20000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mf = 1; md = 1; mw = 0;
      for (int k = 0; k < 2; k++) begin
        e_fp[k] = 0; e_dp[k] = 0; e_sc[k] = 0;
        e_fs[k] = 0; e_rd[k] = 0; e_wr[k] = 0; e_ft[k] = 0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        int pf, pd;
        bit rf, rdd;
        pf = phys_of(fetch_addr, mf, k == 1);
        pd = dat_scratch ? ('h20000 + (dat_addr % 256)) : phys_of(dat_addr, md, k == 1);
        rf = in_rsv(pf, k == 1);
        rdd = in_rsv(pd, k == 1);
        e_fp[k] = pf; e_dp[k] = pd; e_sc[k] = pd / 1024;
        e_fs[k] = fetch_req && !rf;
        e_rd[k] = dat_req && !dat_we && !rdd;
        e_wr[k] = dat_req && dat_we && (mw != 0) && !rdd;
        if ((fetch_req && rf) || (dat_req && rdd)) e_ft[k] = 1;
      end
      if (cfg_we) begin
        if (!cfg_sel) begin mf = cfg_wdata % 4; md = (cfg_wdata / 16) % 4; end
        else mw = cfg_wdata % 2;
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n || tag == "R1") begin
    cmp("banked fetch_phys", fp_b, e_fp[0]);  cmp("banked fetch_stb", fs_b, e_fs[0]);
    cmp("banked data_phys", dp_b, e_dp[0]);   cmp("banked data_rd", rd_b, e_rd[0]);
    cmp("banked data_wr", wr_b, e_wr[0]);     cmp("banked data_sector", sc_b, e_sc[0]);
    cmp("banked fault", ft_b, e_ft[0]);
    cmp("flat fetch_phys", fp_f, e_fp[1]);    cmp("flat fetch_stb", fs_f, e_fs[1]);
    cmp("flat data_phys", dp_f, e_dp[1]);     cmp("flat data_rd", rd_f, e_rd[1]);
    cmp("flat data_wr", wr_f, e_wr[1]);       cmp("flat data_sector", sc_f, e_sc[1]);
    cmp("flat fault", ft_f, e_ft[1]);
  end

  task automatic idle();
    fetch_req = 0; dat_req = 0; dat_we = 0; dat_scratch = 0; cfg_we = 0;
  endtask

  task automatic step(); @(negedge clk); #0.5; endtask

  task automatic fetch(int a); idle(); fetch_req = 1; fetch_addr = 16'(a); step(); endtask
  task automatic dacc(int a, bit we, bit scr);
    idle(); dat_req = 1; dat_we = we; dat_scratch = scr; dat_addr = 16'(a); step();
  endtask
  task automatic cfg(bit sel, int d); idle(); cfg_we = 1; cfg_sel = sel; cfg_wdata = 8'(d); step(); endtask

  task automatic do_reset();
    idle(); rst_n = 0; step(); step(); rst_n = 1; step();
  endtask

  initial begin
    step(); step();
    tag = "R1"; rst_n = 1; step(); idle(); step();
    tag = "R2"; cfg(0, 'h33); fetch('h1234); dacc('h7FFF, 0, 0); step();
    tag = "R3"; cfg(0, 'h00); fetch('h8010); cfg(0, 'h02); fetch('h9234); cfg(0, 'h03); fetch('hABCD); step();
    tag = "R4"; cfg(0, 'h32); dacc('h9234, 0, 0); fetch('h9234); cfg(0, 'h12); dacc('h8001, 0, 0); step();
    tag = "R6"; dacc('h8400, 1, 0); cfg(1, 'hFE); dacc('h8400, 1, 0); cfg(1, 'h01); dacc('h8400, 1, 0); step();
    tag = "R8"; cfg(0, 'h30); dacc('hC7FF, 1, 0); dacc('h0400, 1, 0); step();
    tag = "R7"; dacc('h1255, 1, 1); dacc('hFF00, 0, 1); fetch('hFFFF); step();
    tag = "R9"; idle(); fetch_req = 1; fetch_addr = 16'h8000; cfg_we = 1; cfg_sel = 0; cfg_wdata = 8'h01; step();
    fetch('h8000); idle(); cfg_we = 1; cfg_sel = 1; cfg_wdata = 0; dat_req = 1; dat_we = 1; dat_addr = 16'h0000; step(); dacc('h0000, 1, 0); step();
    tag = "R5"; cfg(0, 'h33); cfg(1, 1); dacc('hFBFF, 1, 0); dacc('hFC00, 1, 0); dacc('hFFFF, 0, 0); fetch('hFE00); fetch('h0000); step();
    tag = "R10"; fetch('hFC00); dacc('hFFFF, 1, 0); step();
    tag = "R1"; do_reset(); step();
    tag = "R3";
    for (int i = 0; i < 2000; i++) begin
      idle();
      fetch_req = 1'($urandom); dat_req = 1'($urandom); dat_we = 1'($urandom);
      dat_scratch = ($urandom % 5) == 0;
      fetch_addr = 16'($urandom); dat_addr = 16'($urandom);
      if ($urandom % 4 == 0) fetch_addr[15:10] = 6'h3F;
      if ($urandom % 4 == 0) dat_addr[15:10] = 6'h3F;
      cfg_we = ($urandom % 3) == 0; cfg_sel = 1'($urandom); cfg_wdata = 8'($urandom);
      if (i == 1000) rst_n = 0;
      if (i == 1002) rst_n = 1;
      step();
    end
    idle(); step(); step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule